// File: doc/BRIEF.md
# Serial Pattern Generator Channel

This block is one channel of a serial pattern generator. It drives a clock line and a data line. The data line shifts out a seed pattern of 1 to 64 bits, least significant bit first. The whole pattern repeats a programmable number of times with no gap between repetitions. The output clock runs at a programmable fraction of the input clock. Its polarity is selectable, and each line has its own level that it holds while the channel is idle.

Configuration inputs are changed only while the enable input is low. A rising enable starts generation, and the channel then runs on its own until every bit of every repetition has been sent. When the last bit completes, the channel raises a one-cycle done pulse and returns both lines to their idle levels. It stays there until enable is cleared and set again. Dropping enable part way through a pattern aborts the transfer at once.

Top module: `patgen_channel`

## Requirements
- R1: While `en` is low, `sclk_o` equals `idle_clk`, `sdat_o` equals `idle_dat`, and `done_o` is 0; this also holds during reset.
- R2: In the first cycle after the clock edge that samples `en` rising, `sdat_o` carries `seed[0]` and `sclk_o` sits at its base level, which is the value of `pol`.
- R3: Each half-period of the output clock lasts `ratio+1` input cycles. The clock leaves its base level one half-period after start, so a full period is `2*(ratio+1)` cycles.
- R4: `sdat_o` changes only when `sclk_o` returns to its base level. With `pol`=0 this is the falling edge. Bits go out in ascending index order starting at bit 0.
- R5: A pattern holds `len_m1+1` bits. After bit `len_m1`, the next bit is `seed[0]` with no idle time in between.
- R6: The pattern is sent `reps_m1+1` times (1 to 1024).
- R7: One full clock period after the last bit of the final repetition began, `done_o` is high for exactly one cycle. In that cycle both lines are at their idle levels, and they stay there while `en` remains high.
- R8: Clearing `en` during generation returns both lines to their idle levels in the same cycle, without a done pulse. A later rising `en` restarts from bit 0 of the first repetition.
- R9: With `pol`=1 the output clock is the inverse of the `pol`=0 clock: it starts high, and data changes on its rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Channel enable; a rising edge starts generation |
| pol | input | 1 | Clock polarity (base level of the output clock) |
| idle_clk | input | 1 | Level of the clock line when inactive |
| idle_dat | input | 1 | Level of the data line when inactive |
| len_m1 | input | LEN_W | Pattern length minus one |
| seed | input | SEED_W | Pattern bits, bit 0 sent first |
| ratio | input | DIV_W | Half-period length minus one, in input cycles |
| reps_m1 | input | REPS_W | Repetition count minus one |
| sclk_o | output | 1 | Generated clock line |
| sdat_o | output | 1 | Generated data line |
| done_o | output | 1 | One-cycle pulse after the final bit |

## Verification
The hardest cases to reach are the pattern wrap boundary and the final repetition, where the bit index, the repetition counter and the prescaler all roll over in the same cycle. The sweep reaches them by running every combination of small lengths, prescale ratios and repetition counts, with both polarities and all four idle-level pairs. It predicts every output cycle from closed-form arithmetic on the elapsed cycle count. Separate runs cover the full 64-bit length and the maximum of 1024 repetitions. An abort mid-pattern followed by an immediate restart shows that no state carries over.

// File: rtl/patgen_channel.sv
module patgen_channel #(
  parameter int SEED_W = 64,
  parameter int REPS_W = 10,
  parameter int DIV_W  = 16,
  localparam int LEN_W = $clog2(SEED_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              pol,
  input  logic              idle_clk,
  input  logic              idle_dat,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic [SEED_W-1:0] seed,
  input  logic [DIV_W-1:0]  ratio,
  input  logic [REPS_W-1:0] reps_m1,
  output logic              sclk_o,
  output logic              sdat_o,
  output logic              done_o
);

  logic              run, ph, en_q, done_q;
  logic [DIV_W-1:0]  cnt;
  logic [LEN_W-1:0]  idx;
  logic [REPS_W-1:0] rep;

  wire active   = run & en;
  wire half_end = (cnt == ratio);
  wire last_bit = (idx == len_m1);
  wire last_rep = (rep == reps_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      ph     <= 1'b0;
      en_q   <= 1'b0;
      done_q <= 1'b0;
      cnt    <= '0;
      idx    <= '0;
      rep    <= '0;
    end else begin
      en_q   <= en;
      done_q <= 1'b0;
      if (!en) begin
        run <= 1'b0;
      end else if (!run) begin
        if (!en_q) begin
          run <= 1'b1;
          ph  <= 1'b0;
          cnt <= '0;
          idx <= '0;
          rep <= '0;
        end
      end else if (half_end) begin
        cnt <= '0;
        ph  <= ~ph;
        if (ph) begin
          if (last_bit) begin
            idx <= '0;
            if (last_rep) begin
              run    <= 1'b0;
              done_q <= 1'b1;
            end else begin
              rep <= rep + 1'b1;
            end
          end else begin
            idx <= idx + 1'b1;
          end
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign sclk_o = active ? (ph ^ pol) : idle_clk;
  assign sdat_o = active ? seed[idx]  : idle_dat;
  assign done_o = done_q;

endmodule

// File: rtl/patgen_channel_chk.sv
module patgen_channel_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic pol,
  input logic idle_clk,
  input logic idle_dat,
  input logic sclk_o,
  input logic sdat_o,
  input logic done_o
);

  p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (sclk_o == idle_clk && sdat_o == idle_dat && !done_o));

  p_start_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |=> (!en || sclk_o == pol));

  p_data_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !done_o && sclk_o == ~pol && $past(sclk_o) == ~pol)
      |-> $stable(sdat_o));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (sclk_o == idle_clk && sdat_o == idle_dat));

endmodule

bind patgen_channel patgen_channel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .pol(pol),
  .idle_clk(idle_clk), .idle_dat(idle_dat),
  .sclk_o(sclk_o), .sdat_o(sdat_o), .done_o(done_o)
);

// File: tb/tb_patgen_channel.sv
`timescale 1ns/1ps
module tb_patgen_channel;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, pol = 1'b0, idle_clk = 1'b0, idle_dat = 1'b0;
  logic [5:0]  len_m1 = '0;
  logic [63:0] seed = '0;
  logic [15:0] ratio = '0;
  logic [9:0]  reps_m1 = '0;
  logic        sclk_o, sdat_o, done_o;

  int checks = 0;
  int errors = 0;
  bit reported = 0;

  always #10 clk = ~clk;

  patgen_channel dut (
    .clk(clk), .rst_n(rst_n), .en(en), .pol(pol),
    .idle_clk(idle_clk), .idle_dat(idle_dat), .len_m1(len_m1),
    .seed(seed), .ratio(ratio), .reps_m1(reps_m1),
    .sclk_o(sclk_o), .sdat_o(sdat_o), .done_o(done_o)
  );

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
  endtask

  task automatic chk(input bit ok, input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      if (errors < 30)
        $display("FAIL %s at %0t: actual clk/dat/done=%b expected %b", req, $time, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    logic [2:0] a, e;
    a = {sclk_o, sdat_o, done_o};
    e = {idle_clk, idle_dat, 1'b0};
    chk(a == e, req, a, e);
  endtask

  // R2 R3 R4 R5 R6 R7 R9: full cycle-by-cycle comparison of one run
  task automatic run_case(input bit p, input bit ic, input bit id, input int len,
                          input int rat, input int reps, input logic [63:0] s);
    int h, tot;
    @(negedge clk);
    pol = p; idle_clk = ic; idle_dat = id; len_m1 = 6'(len);
    ratio = 16'(rat); reps_m1 = 10'(reps); seed = s; en = 1'b0;
    #1 check_idle("R1");
    @(negedge clk);
    en = 1'b1;
    h = rat + 1;
    tot = (len + 1) * (reps + 1) * 2 * h;
    for (int t = 0; t <= tot + 3; t++) begin
      logic [2:0] a, e;
      string req;
      @(posedge clk);
      #5;
      if (t < tot) begin
        int b, ph;
        b  = t / (2 * h);
        ph = ((t % (2 * h)) >= h) ? 1 : 0;
        e  = {1'(ph) ^ p, s[b % (len + 1)], 1'b0};
        if (t == 0) req = "R2";
        else if (p) req = "R9";
        else if (b > len) req = "R5";
        else req = "R4";
      end else begin
        e   = {ic, id, (t == tot) ? 1'b1 : 1'b0};
        req = "R7";
      end
      a = {sclk_o, sdat_o, done_o};
      chk(a == e, req, a, e);
    end
    @(negedge clk);
    en = 1'b0;
    #1 check_idle("R1");
  endtask

  initial begin
    #(20ns * 200000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1");

    // R3 R4 R5 R6 R9: sweep over polarity, idle levels, length, ratio, repetitions
    for (int p = 0; p < 2; p++)
      for (int il = 0; il < 4; il++)
        for (int li = 0; li < 4; li++)
          for (int r = 0; r < 3; r++)
            for (int rp = 0; rp < 2; rp++) begin
              int ln, idx;
              logic [63:0] s;
              ln  = (li == 0) ? 0 : (li == 1) ? 1 : (li == 2) ? 3 : 6;
              idx = ((p * 4 + il) * 4 + li) * 6 + r * 2 + rp;
              s   = {32'(idx * 32'h9E3779B9), 32'(~idx * 32'h85EBCA6B)};
              run_case(1'(p), 1'(il >> 1), 1'(il), ln, r, rp * 2, s);
            end

    // R5: full 64-bit pattern with wrap
    run_case(1'b0, 1'b1, 1'b0, 63, 0, 1, 64'hF00D_1234_8BAD_C0DE);
    // R6: maximum repetition count
    run_case(1'b1, 1'b0, 1'b1, 0, 0, 1023, 64'h1);

    // R8: abort mid-pattern, then restart from bit 0
    @(negedge clk);
    pol = 1'b0; idle_clk = 1'b1; idle_dat = 1'b1; len_m1 = 6'd5;
    ratio = 16'd2; reps_m1 = 10'd3; seed = 64'h2A;
    en = 1'b1;
    repeat (17) @(negedge clk);
    en = 1'b0;
    #1 check_idle("R8");
    for (int k = 0; k < 4; k++) begin
      @(posedge clk);
      #5 check_idle("R8");
    end
    run_case(1'b0, 1'b1, 1'b1, 5, 2, 3, 64'h2A);

    repeat (2) @(negedge clk);
    report();
    $finish;
  end

endmodule